// File: doc/BRIEF.md
# Playback DMA Count and Interrupt Tracker

This block follows the progress of an audio playback stream, one byte at a time. Software programs a 16-bit sample count and a format byte. The block decodes the format byte into three things: a clock source, a rate index and a channel mode. From the sample encoding it then derives how many bytes each sample occupies. The byte terminal count is the sample count shifted left by that byte shift.

While playback is enabled and the format is legal, the block drives a DMA request level. The memory side reports each moved byte with a one-cycle strobe. When the number of counted bytes reaches the terminal count, the block raises its interrupt flags, restarts the count from zero and drops the request for one cycle. This pause lets the interrupt be seen before transfers resume. The flags stay set until a clear pulse arrives.

Top module: `pb_dma_tracker`

## Requirements
- R1: After reset, dma_req, irq, status_int and pb_int are all 0.
- R2: The rate field is fmt_byte[3:1], output on rate_idx, and the clock source is fmt_byte[0], output on clk_src. With clk_src 0, rate_idx 4 and rate_idx 5 are illegal: fmt_ok is 0 and dma_req stays 0 even while playback is enabled. Every rate_idx with clk_src 1 is legal.
- R3: The encoding code is {0, fmt_byte[6:5]} when ext_mode is 0, so bit 7 has no effect. It is fmt_byte[7:5] when ext_mode is 1. Codes 4, 5 and 7 are rejected: fmt_ok is 0 and dma_req is 0.
- R4: fmt_byte[4] set selects stereo. For codes 0, 1 and 3, shift is 1 in stereo and 0 in mono.
- R5: For codes 2 and 6, shift is 2 in stereo and 1 in mono.
- R6: dma_req rises one cycle after play_en goes high with a legal format. It falls one cycle after play_en goes low.
- R7: A counted byte is an xfer_valid cycle while enabled with irq_en high. The counted byte that brings the count to base_count << shift sets status_int, pb_int and irq on the next cycle, and counting restarts from zero.
- R8: dma_req is low for exactly one cycle after the terminal byte, then returns high.
- R9: xfer_valid cycles while irq_en is 0 neither advance the count nor raise the flags.
- R10: The flags remain set until a cycle with irq_clr high. They read 0 in the following cycle.
- R11: Re-enabling playback after a disable restarts the count from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fmt_byte | input | 8 | Playback format byte |
| ext_mode | input | 1 | Selects the 3-bit encoding field |
| base_count | input | 16 | Programmed sample count |
| play_en | input | 1 | Playback enable |
| irq_en | input | 1 | Enables byte counting and interrupts |
| xfer_valid | input | 1 | One byte moved this cycle |
| irq_clr | input | 1 | Clears the interrupt flags |
| dma_req | output | 1 | DMA request level |
| irq | output | 1 | Interrupt line |
| status_int | output | 1 | Summary interrupt status flag |
| pb_int | output | 1 | Playback interrupt flag |
| fmt_ok | output | 1 | Format and rate are legal |
| shift | output | 2 | Bytes-per-sample shift |
| stereo | output | 1 | Stereo selected |
| clk_src | output | 1 | Clock source select |
| rate_idx | output | 3 | Rate index |

## Verification
The scoreboard records the expected number of bytes between successive interrupts for every mix of encoding and channel mode. A wrong shift therefore shows up as an early or late interrupt.

The bench probes the two illegal rates and the three rejected codes, and checks that bit 7 is ignored in normal mode. A faulty decode would keep requesting DMA on an illegal format.

It looks for the one-cycle gap in the request right after the terminal byte, and for flags that persist until cleared. It also checks that bytes arriving with interrupts disabled leave the count alone, and that re-enabling playback discards any partial count. A design that missed either rule would interrupt after the wrong number of bytes.

// File: rtl/pb_trk_pkg.sv
`timescale 1ns/1ps
package pb_trk_pkg;

    localparam int PB_SHIFT_W   = 2;
    localparam int PB_MAX_SHIFT = 2;

    typedef enum logic [2:0] {
        ENC_U8    = 3'd0,
        ENC_ULAW  = 3'd1,
        ENC_S16LE = 3'd2,
        ENC_ALAW  = 3'd3,
        ENC_RSV4  = 3'd4,
        ENC_ADPCM = 3'd5,
        ENC_S16BE = 3'd6,
        ENC_RSV7  = 3'd7
    } pb_enc_e;

    typedef struct packed {
        logic                  clk_src;
        logic [2:0]            rate_idx;
        logic                  stereo;
        pb_enc_e               enc;
        logic [PB_SHIFT_W-1:0] shift;
        logic                  valid;
    } pb_fmt_t;

endpackage

// File: rtl/pb_fmt_decode.sv
`timescale 1ns/1ps
module pb_fmt_decode
    import pb_trk_pkg::*;
#(
    parameter logic [7:0] SRC0_BAD_RATES = 8'b0011_0000
) (
    input  logic [7:0] fmt_byte,
    input  logic       ext_mode,
    output pb_fmt_t    info
);

    logic rate_ok;
    logic enc_ok;

    always_comb begin
        info          = '0;
        info.clk_src  = fmt_byte[0];
        info.rate_idx = fmt_byte[3:1];
        info.stereo   = fmt_byte[4];
        info.enc      = ext_mode ? pb_enc_e'(fmt_byte[7:5])
                                 : pb_enc_e'({1'b0, fmt_byte[6:5]});

        rate_ok = fmt_byte[0] | ~SRC0_BAD_RATES[fmt_byte[3:1]];

        enc_ok = 1'b1;
        unique case (info.enc)
            ENC_U8, ENC_ULAW, ENC_ALAW:
                info.shift = info.stereo ? PB_SHIFT_W'(1) : PB_SHIFT_W'(0);
            ENC_S16LE, ENC_S16BE:
                info.shift = info.stereo ? PB_SHIFT_W'(2) : PB_SHIFT_W'(1);
            default: begin
                info.shift = '0;
                enc_ok     = 1'b0;
            end
        endcase

        info.valid = rate_ok & enc_ok;
    end

endmodule

// File: rtl/pb_byte_counter.sv
`timescale 1ns/1ps
module pb_byte_counter
    import pb_trk_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  play_en,
    input  logic                  irq_en,
    input  logic                  fmt_ok,
    input  logic [PB_SHIFT_W-1:0] shift,
    input  logic [CNT_W-1:0]      base_count,
    input  logic                  xfer_valid,
    output logic                  dma_req,
    output logic                  hit
);

    localparam int TERM_W = CNT_W + PB_MAX_SHIFT;

    typedef struct packed {
        logic              running;
        logic              hold;
        logic [TERM_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t        st_d, st_q;
    logic [TERM_W-1:0] term;
    logic [TERM_W-1:0] cnt_inc;

    always_comb begin
        st_d    = st_q;
        hit     = 1'b0;
        term    = TERM_W'(base_count) << shift;
        cnt_inc = st_q.cnt + TERM_W'(1);

        if (!play_en) begin
            st_d.running = 1'b0;
            st_d.hold    = 1'b0;
        end else if (!st_q.running) begin
            st_d.running = 1'b1;
            st_d.hold    = 1'b0;
            st_d.cnt     = '0;
        end else begin
            st_d.hold = 1'b0;
            if (xfer_valid && irq_en) begin
                if (term != '0 && cnt_inc == term) begin
                    hit       = 1'b1;
                    st_d.cnt  = '0;
                    st_d.hold = 1'b1;
                end else begin
                    st_d.cnt = cnt_inc;
                end
            end
        end

        dma_req = st_q.running & fmt_ok & ~st_q.hold;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/pb_irq_flags.sv
`timescale 1ns/1ps
module pb_irq_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic irq_clr,
    output logic status_int,
    output logic pb_int
);

    typedef struct packed {
        logic status;
        logic pb;
    } flag_state_t;

    flag_state_t fl_d, fl_q;

    always_comb begin
        fl_d = fl_q;
        if (irq_clr) fl_d = '0;
        if (hit) begin
            fl_d.status = 1'b1;
            fl_d.pb     = 1'b1;
        end
        status_int = fl_q.status;
        pb_int     = fl_q.pb;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fl_q <= '0;
        else        fl_q <= fl_d;
    end

endmodule

// File: rtl/pb_dma_tracker.sv
`timescale 1ns/1ps
module pb_dma_tracker
    import pb_trk_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [7:0]            fmt_byte,
    input  logic                  ext_mode,
    input  logic [CNT_W-1:0]      base_count,
    input  logic                  play_en,
    input  logic                  irq_en,
    input  logic                  xfer_valid,
    input  logic                  irq_clr,
    output logic                  dma_req,
    output logic                  irq,
    output logic                  status_int,
    output logic                  pb_int,
    output logic                  fmt_ok,
    output logic [PB_SHIFT_W-1:0] shift,
    output logic                  stereo,
    output logic                  clk_src,
    output logic [2:0]            rate_idx
);

    pb_fmt_t info;
    logic    hit;

    pb_fmt_decode u_dec (
        .fmt_byte (fmt_byte),
        .ext_mode (ext_mode),
        .info     (info)
    );

    pb_byte_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .play_en    (play_en),
        .irq_en     (irq_en),
        .fmt_ok     (info.valid),
        .shift      (info.shift),
        .base_count (base_count),
        .xfer_valid (xfer_valid),
        .dma_req    (dma_req),
        .hit        (hit)
    );

    pb_irq_flags u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .hit        (hit),
        .irq_clr    (irq_clr),
        .status_int (status_int),
        .pb_int     (pb_int)
    );

    assign irq      = status_int;
    assign fmt_ok   = info.valid;
    assign shift    = info.shift;
    assign stereo   = info.stereo;
    assign clk_src  = info.clk_src;
    assign rate_idx = info.rate_idx;

endmodule

// File: rtl/pb_dma_tracker_chk.sv
`timescale 1ns/1ps
module pb_dma_tracker_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       play_en,
    input logic       irq_en,
    input logic       irq_clr,
    input logic       fmt_ok,
    input logic       dma_req,
    input logic       irq,
    input logic       pb_int,
    input logic [1:0] shift,
    input logic       hit
);

    a_r2_illegal_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        !fmt_ok |-> !dma_req);

    a_r5_shift_range: assert property (@(posedge clk) disable iff (!rst_n)
        shift != 2'd3);

    a_r6_off_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(play_en) |-> !dma_req);

    a_r7_irq_pauses_req: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pb_int) |-> !dma_req);

    a_r8_gap_after_hit: assert property (@(posedge clk) disable iff (!rst_n)
        $past(hit) |-> !dma_req);

    a_r9_no_irq_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!irq_en) && !$past(pb_int)) |-> !pb_int);

    a_r10_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(irq_clr) && !$past(hit)) |-> (!irq && !pb_int));

endmodule

bind pb_dma_tracker pb_dma_tracker_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .play_en (play_en),
    .irq_en  (irq_en),
    .irq_clr (irq_clr),
    .fmt_ok  (fmt_ok),
    .dma_req (dma_req),
    .irq     (irq),
    .pb_int  (pb_int),
    .shift   (shift),
    .hit     (hit)
);

// File: tb/test_pb_dma_tracker.sv
`timescale 1ns/1ps
module test_pb_dma_tracker;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  fmt_byte = 8'h00;
    logic        ext_mode = 1'b0;
    logic [15:0] base_count = 16'd3;
    logic        play_en = 1'b0;
    logic        irq_en = 1'b1;
    logic        xfer_valid = 1'b0;
    logic        irq_clr = 1'b0;
    logic        dma_req, irq, status_int, pb_int, fmt_ok, stereo, clk_src;
    logic [1:0]  shift;
    logic [2:0]  rate_idx;

    int checks = 0;
    int fails = 0;
    int since = 0;
    int exp_q[$];
    bit done = 0;

    always #4 clk = ~clk;

    pb_dma_tracker i_pb_dma_tracker (
        .clk(clk), .rst_n(rst_n), .fmt_byte(fmt_byte), .ext_mode(ext_mode),
        .base_count(base_count), .play_en(play_en), .irq_en(irq_en),
        .xfer_valid(xfer_valid), .irq_clr(irq_clr), .dma_req(dma_req),
        .irq(irq), .status_int(status_int), .pb_int(pb_int), .fmt_ok(fmt_ok),
        .shift(shift), .stereo(stereo), .clk_src(clk_src), .rate_idx(rate_idx)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", checks, fails);
    endtask

    // monitor: compares bytes between interrupts with the queued expectation
    initial begin
        logic prev = 1'b0;
        forever begin
            @(posedge clk); #2;
            if (pb_int && !prev) begin
                if (exp_q.size() == 0) chk("R7 unexpected interrupt", 1, 0);
                else chk("R7 bytes per interrupt", since, exp_q.pop_front());
                since = 0;
            end
            prev = pb_int;
        end
    end

    task automatic start_play(input logic [7:0] f, input logic ext, input logic [15:0] base);
        @(negedge clk);
        play_en = 1'b0; fmt_byte = f; ext_mode = ext; base_count = base;
        @(negedge clk);
        play_en = 1'b1; since = 0;
        @(negedge clk);
    endtask

    task automatic send_bytes(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            xfer_valid = 1'b1;
            if (irq_en) since++;
        end
        @(negedge clk);
        xfer_valid = 1'b0;
    endtask

    task automatic frame(input int term, input string tag);
        exp_q.push_back(term);
        send_bytes(term);
        chk({tag, " R8 request gap"}, dma_req, 0);
        @(posedge clk); #2;
        chk({tag, " R8 request back"}, dma_req, 1);
        chk({tag, " R10 flag held"}, pb_int, 1);
        chk({tag, " R7 status flag"}, status_int, 1);
        @(negedge clk); irq_clr = 1'b1;
        @(negedge clk); irq_clr = 1'b0;
        chk({tag, " R10 flag cleared"}, pb_int, 0);
        chk({tag, " R10 irq cleared"}, irq, 0);
    endtask

    task automatic fmt_probe(input logic [7:0] f, input logic ext, input int ok, input int sh, input string tag);
        fmt_byte = f; ext_mode = ext; #1;
        chk({tag, " fmt_ok"}, fmt_ok, ok);
        chk({tag, " dma_req"}, dma_req, ok);
        if (ok) chk({tag, " shift"}, shift, sh);
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual=1 expected=0");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 dma_req reset", dma_req, 0);
        chk("R1 irq reset", irq, 0);
        chk("R1 pb_int reset", pb_int, 0);
        chk("R1 status reset", status_int, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R6 no request before enable", dma_req, 0);

        // R4: 8-bit encodings
        start_play(8'h00, 1'b0, 16'd3);
        chk("R6 request after enable", dma_req, 1);
        chk("R4 mono u8 shift", shift, 0);
        frame(3, "R4 u8 mono a");
        frame(3, "R4 u8 mono b");
        start_play(8'h10, 1'b0, 16'd3);
        chk("R4 stereo u8 shift", shift, 1);
        frame(6, "R4 u8 stereo");
        start_play(8'h30, 1'b0, 16'd3);
        frame(6, "R4 mulaw stereo");
        start_play(8'h60, 1'b0, 16'd3);
        frame(3, "R4 alaw mono");

        // R5: 16-bit encodings
        start_play(8'h40, 1'b0, 16'd3);
        chk("R5 le mono shift", shift, 1);
        frame(6, "R5 le mono");
        start_play(8'h50, 1'b0, 16'd3);
        chk("R5 le stereo shift", shift, 2);
        frame(12, "R5 le stereo");
        start_play(8'hC0, 1'b1, 16'd3);
        frame(6, "R5 be mono");
        start_play(8'hD0, 1'b1, 16'd3);
        frame(12, "R5 be stereo");

        // R3: encoding field width and rejected codes (playback enabled)
        @(negedge clk);
        fmt_probe(8'hC0, 1'b0, 1, 1, "R3 normal bit7 ignored");
        fmt_probe(8'h80, 1'b0, 1, 0, "R3 normal 0x80");
        fmt_probe(8'hE0, 1'b0, 1, 0, "R3 normal 0xE0");
        fmt_probe(8'h80, 1'b1, 0, 0, "R3 ext code4");
        fmt_probe(8'hA0, 1'b1, 0, 0, "R3 ext code5");
        fmt_probe(8'hE0, 1'b1, 0, 0, "R3 ext code7");

        // R2: rate validity
        fmt_probe(8'h08, 1'b0, 0, 0, "R2 src0 rate4");
        fmt_probe(8'h0A, 1'b0, 0, 0, "R2 src0 rate5");
        chk("R2 rate_idx field", rate_idx, 5);
        chk("R2 clk_src field", clk_src, 0);
        fmt_probe(8'h09, 1'b0, 1, 0, "R2 src1 rate4");
        chk("R2 clk_src set", clk_src, 1);
        fmt_probe(8'h0C, 1'b0, 1, 0, "R2 src0 rate6");

        // R9: bytes ignored while interrupts disabled
        start_play(8'h00, 1'b0, 16'd3);
        irq_en = 1'b0;
        send_bytes(10);
        @(posedge clk); #2;
        chk("R9 no flag while disabled", pb_int, 0);
        @(negedge clk); irq_en = 1'b1;
        frame(3, "R9 count untouched");

        // R11: re-enable restarts count
        start_play(8'h00, 1'b0, 16'd3);
        send_bytes(2);
        @(negedge clk); play_en = 1'b0;
        @(negedge clk);
        chk("R6 request drops on disable", dma_req, 0);
        play_en = 1'b1; since = 0;
        @(negedge clk);
        frame(3, "R11 fresh count");

        repeat (3) @(negedge clk);
        chk("R7 all interrupts seen", exp_q.size(), 0);
        done = 1;
        summary();
        $finish;
    end

endmodule